// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

This block watches one asynchronous external interrupt line. It passes the line through a synchronizer and then detects a falling edge, a rising edge or both edges, as a small 4-bit control register selects. A detected edge latches an interrupt request flag. The flag stays set until software issues a test-and-clear strobe. That strobe returns the flag's value in the same cycle and clears the flag on the next clock edge.

The control register is written from a 4-bit accumulator-style data bus and read back in full on a separate read bus. The block also gives a level-sense output and a gate output. The level-sense output is high when the synchronized line sits at the active level that the polarity bit picks. The gate output drives the count enable of a companion timer. Changing the polarity bit while the line already sits at the newly selected level counts as an event and sets the request flag, so software clears the flag after it reprograms the polarity.

The design has two state machines. The line tracker has the states `LVL_LOW` and `LVL_HIGH`. Its transitions are RISE (from `LVL_LOW` when the synchronized sample is 1) and FALL (from `LVL_HIGH` when the sample is 0). The request flag has the states `FLG_CLEAR` and `FLG_PENDING`. Its transitions are SET (from `FLG_CLEAR` on any event) and ACK (from `FLG_PENDING` on a test-and-clear strobe when no event arrives in that cycle). An event together with ACK keeps `FLG_PENDING`.

Top module: `exti_edge_detector`

## Requirements
- R1: After reset the control register reads 0000 and the request flag is 0.
- R2: A write strobe loads the 4-bit data bus into the control register on the next clock edge. All four bits read back unchanged, including bit 3, which has no other effect.
- R3: With bit 1 = 0 and bit 2 = 0, a falling edge of the line sets the request flag and a rising edge does not.
- R4: With bit 1 = 0 and bit 2 = 1, a rising edge of the line sets the request flag and a falling edge does not.
- R5: With bit 1 = 1, both rising and falling edges set the request flag, whatever bit 2 holds.
- R6: The request flag holds its value until a test-and-clear strobe. While the strobe is high, the test output shows the flag, and the flag is 0 after the clock edge that ends the strobe.
- R7: If an edge event is present in the same cycle as the test-and-clear strobe, the flag stays set.
- R8: A write that changes bit 2 sets the request flag on that write's clock edge when the synchronized line equals the new bit-2 value. If the line does not equal the new value, the write leaves the flag unchanged. A write that keeps bit 2 never sets the flag.
- R9: The level output is 1 exactly when the synchronized line equals bit 2 (0 means active low, 1 means active high).
- R10: The timer gate output is bit 0 ANDed with the level output. When bit 0 is 0 the gate stays 0 whatever the line does.
- R11: A line change shows on the level output after the second rising clock edge and on the request flag after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous external interrupt line |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 4 | Data bus value to write (bit0 timer gate enable, bit1 both edges, bit2 polarity, bit3 spare) |
| rd_data_o | output | 4 | Control register read back |
| ack_i | input | 1 | Test-and-clear strobe for the request flag |
| ack_flag_o | output | 1 | Flag value returned while the strobe is high, else 0 |
| req_o | output | 1 | Interrupt request flag |
| level_o | output | 1 | Synchronized line equals the selected active level |
| tmr_gate_o | output | 1 | Count enable for the companion timer |

## Verification
The assertions assume that the strobes and the write bus are synchronous to the clock and stable around each rising edge. Only the external line may change without regard to the clock. The bench drives every input one nanosecond after a rising edge and samples at the falling edge. It holds each line level for at least four cycles, so every edge travels through the synchronizer before the next one arrives. For the R7 case the bench places the clear strobe in the one cycle where the edge event is visible, which it counts from the line change.

// File: rtl/exti_pkg.sv
package exti_pkg;
    localparam int CTRL_W = 4;

    typedef struct packed {
        logic spare;      // bit 3: storage only
        logic pol_hi;     // bit 2: 0 = falling/low, 1 = rising/high
        logic both_edges; // bit 1: 1 = detect either edge
        logic tmr_en;     // bit 0: line gates companion timer
    } exti_ctrl_t;

    typedef enum logic {
        LVL_LOW,
        LVL_HIGH
    } line_state_e;

    typedef enum logic {
        FLG_CLEAR,
        FLG_PENDING
    } flag_state_e;
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/exti_edge_fsm.sv
module exti_edge_fsm
    import exti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic rise_o,
    output logic fall_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (sample_i)  state_d = LVL_HIGH; // RISE
            LVL_HIGH: if (!sample_i) state_d = LVL_LOW;  // FALL
            default:  state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise_o = sample_i;
            LVL_HIGH: fall_o = !sample_i;
            default: ;
        endcase
    end

    assert_rise_lands_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> (state_q == LVL_HIGH));
    assert_fall_lands_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> (state_q == LVL_LOW));
endmodule

// File: rtl/exti_ctrl_reg.sv
module exti_ctrl_reg
    import exti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output exti_ctrl_t        ctrl_o,
    output logic              pol_flip_o,
    output logic              new_pol_o
);
    exti_ctrl_t ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_en_i) ctrl_q <= exti_ctrl_t'(wr_data_i);
    end

    assign ctrl_o     = ctrl_q;
    assign new_pol_o  = wr_data_i[2];
    assign pol_flip_o = wr_en_i && (wr_data_i[2] != ctrl_q.pol_hi);

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (CTRL_W'(ctrl_o) == $past(wr_data_i)));
    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ctrl_o));
endmodule

// File: rtl/exti_flag_fsm.sv
module exti_flag_fsm
    import exti_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (set_i)           state_d = FLG_PENDING; // SET
            FLG_PENDING: if (ack_i && !set_i) state_d = FLG_CLEAR;   // ACK
            default:     state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_PENDING: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !flag_o);
    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i) |=> flag_o);
    assert_ack_race_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && set_i) |=> flag_o);
endmodule

// File: rtl/exti_edge_detector.sv
module exti_edge_detector
    import exti_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    input  logic              ack_i,
    output logic              ack_flag_o,
    output logic              req_o,
    output logic              level_o,
    output logic              tmr_gate_o
);
    logic       samp;
    logic       rise, fall;
    logic       pol_flip, new_pol;
    logic       edge_hit, pseudo_hit, set_evt;
    exti_ctrl_t ctrl;

    exti_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (line_i),
        .q_o   (samp)
    );

    exti_edge_fsm u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (samp),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    exti_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .ctrl_o     (ctrl),
        .pol_flip_o (pol_flip),
        .new_pol_o  (new_pol)
    );

    always_comb begin
        if (ctrl.both_edges) edge_hit = rise | fall;
        else if (ctrl.pol_hi) edge_hit = rise;
        else                  edge_hit = fall;
    end

    assign pseudo_hit = pol_flip && (samp == new_pol);
    assign set_evt    = edge_hit | pseudo_hit;

    exti_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_evt),
        .ack_i  (ack_i),
        .flag_o (req_o)
    );

    assign rd_data_o  = CTRL_W'(ctrl);
    assign level_o    = (samp == ctrl.pol_hi);
    assign tmr_gate_o = ctrl.tmr_en & level_o;
    assign ack_flag_o = ack_i & req_o;

    assert_pseudo_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_flip && (samp == new_pol)) |=> req_o);
    assert_gate_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[0] == 1'b0) |-> !tmr_gate_o);
    assert_single_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && rise && rd_data_o[2:1] == 2'b00 && !wr_en_i) |=> !req_o);
endmodule

// File: tb/tb_exti_edge_detector.sv
module tb_exti_edge_detector;
    localparam int SIG_RD = 0, SIG_REQ = 1, SIG_ACK = 2, SIG_LVL = 3, SIG_GATE = 4;

    typedef struct {
        string      tag;
        int         sig;
        logic [3:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_data_i = 4'h0;
    logic       ack_i = 1'b0;
    logic [3:0] rd_data_o;
    logic       ack_flag_o, req_o, level_o, tmr_gate_o;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    exti_edge_detector dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .ack_i      (ack_i),
        .ack_flag_o (ack_flag_o),
        .req_o      (req_o),
        .level_o    (level_o),
        .tmr_gate_o (tmr_gate_o)
    );

    function automatic logic [3:0] observe(int sig);
        case (sig)
            SIG_RD:   return rd_data_o;
            SIG_REQ:  return {3'b0, req_o};
            SIG_ACK:  return {3'b0, ack_flag_o};
            SIG_LVL:  return {3'b0, level_o};
            default:  return {3'b0, tmr_gate_o};
        endcase
    endfunction

    // monitor: pops expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = observe(it.sig);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s sig%0d actual=%b expected=%b", it.tag, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(string tag, int sig, logic [3:0] v);
        item_t it;
        it.tag = tag; it.sig = sig; it.exp = v;
        q.push_back(it);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_ctrl(logic [3:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic ack_expect(string tag, logic v);
        ack_i = 1'b1;
        expect_v(tag, SIG_ACK, {3'b0, v});
        tick();
        ack_i = 1'b0;
        expect_v(tag, SIG_REQ, 4'h0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        expect_v("R1 reset ctrl", SIG_RD, 4'h0);
        expect_v("R1 reset flag", SIG_REQ, 4'h0);
        tick(3);
        expect_v("R9 low active, line low", SIG_LVL, 4'h1);
        expect_v("R10 gate off when disabled", SIG_GATE, 4'h0);

        // falling-only mode
        line_i = 1'b1;
        tick(4);
        expect_v("R3 rise ignored", SIG_REQ, 4'h0);
        expect_v("R10 gate stays off", SIG_GATE, 4'h0);
        line_i = 1'b0;
        tick(2);
        expect_v("R11 level after two edges", SIG_LVL, 4'h1);
        expect_v("R11 flag not yet", SIG_REQ, 4'h0);
        tick();
        expect_v("R3 fall sets flag", SIG_REQ, 4'h1);
        tick(3);
        expect_v("R6 flag holds", SIG_REQ, 4'h1);
        ack_expect("R6 ack returns 1", 1'b1);
        ack_expect("R6 ack on clear flag", 1'b0);

        // rising-only, timer gate on; line low so no pseudo edge
        write_ctrl(4'b0101);
        expect_v("R2 readback", SIG_RD, 4'b0101);
        expect_v("R8 no pseudo edge", SIG_REQ, 4'h0);
        expect_v("R9 high active, line low", SIG_LVL, 4'h0);
        line_i = 1'b1;
        tick(2);
        expect_v("R10 gate follows level", SIG_GATE, 4'h1);
        expect_v("R11 flag not yet", SIG_REQ, 4'h0);
        tick();
        expect_v("R4 rise sets flag", SIG_REQ, 4'h1);
        ack_expect("R4 ack", 1'b1);
        line_i = 1'b0;
        tick(4);
        expect_v("R4 fall ignored", SIG_REQ, 4'h0);
        expect_v("R10 gate drops", SIG_GATE, 4'h0);

        // both edges, low active, spare bit set; line low => pseudo edge
        write_ctrl(4'b1011);
        expect_v("R2 readback spare", SIG_RD, 4'b1011);
        expect_v("R8 pseudo edge sets flag", SIG_REQ, 4'h1);
        ack_expect("R8 ack", 1'b1);
        write_ctrl(4'b1011);
        expect_v("R8 same polarity no flag", SIG_REQ, 4'h0);
        line_i = 1'b1;
        tick(3);
        expect_v("R5 rise sets flag", SIG_REQ, 4'h1);
        ack_expect("R5 ack", 1'b1);
        tick(2);
        line_i = 1'b0;
        tick(3);
        expect_v("R5 fall sets flag", SIG_REQ, 4'h1);
        expect_v("R10 gate on, level low", SIG_GATE, 4'h1);
        tick(2);

        // ack in the same cycle as a new edge event
        line_i = 1'b1;
        tick(2);
        ack_i = 1'b1;
        expect_v("R7 ack returns 1", SIG_ACK, 4'h1);
        tick();
        ack_i = 1'b0;
        expect_v("R7 flag kept", SIG_REQ, 4'h1);
        ack_expect("R7 later ack", 1'b1);

        // polarity flip to high with line high => pseudo edge
        write_ctrl(4'b0100);
        expect_v("R8 flip with line at new level", SIG_REQ, 4'h1);
        ack_expect("R8 ack", 1'b1);
        write_ctrl(4'b1000);
        expect_v("R2 spare only readback", SIG_RD, 4'b1000);
        expect_v("R8 flip, line not at new level", SIG_REQ, 4'h0);
        expect_v("R9 low active, line high", SIG_LVL, 4'h0);
        expect_v("R10 gate disabled", SIG_GATE, 4'h0);

        @(negedge clk);
        #1;
        finished = 1'b1;
        report();
    end
endmodule